// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block sits behind the data register of a SCSI host adapter and carries the bytes of programmed-I/O transfers. A write to the data register goes one of two ways. In command-collection mode it is appended to a separate command buffer, which the command logic later reads by index. Otherwise it is queued in the data FIFO. Reads drain the FIFO in arrival order and keep a signed transfer-size count up to date.

The block also serves two adapter commands. A status-response load replaces the FIFO content with a two-byte response: the status byte followed by a zero byte. A flush sets the interrupt code to "function complete" and clears the flags register. The flags register reports the FIFO byte count that the status-response load installs. The current bus phase comes in from the status register. When the phase bits are all zero, the bus is in the data-out phase and reads are refused.

Storage uses two pointers that both return to index zero whenever a read empties the FIFO. The FIFO refuses a write one slot before its storage is full, so it holds at most DEPTH-1 bytes. Command execution and DMA belong to other blocks.

Top module: `pio_byte_fifo`

## Requirements
- R1: A data write (`wr_en`) while `cmd_mode` is 1 stores `wr_data` at command index `cmd_len` and increments `cmd_len` when `cmd_len` < CMD_DEPTH. The data FIFO and `xfer_size` are unchanged, and the stored byte appears on `cmd_byte` when `cmd_idx` selects it.
- R2: A command-mode write with `cmd_len` equal to CMD_DEPTH is dropped: `cmd_len` stays unchanged and `overrun` is 1 for the cycle after the write.
- R3: A data write outside command mode is stored and increments `xfer_size` unless the write index equals DEPTH-1. In that case it is dropped, `xfer_size` holds, and `overrun` is 1 for the following cycle. The FIFO therefore holds at most DEPTH-1 bytes.
- R4: A read (`rd_en`) with `phase` equal to 3'b000 (data out) sets `rd_data` to 0x00 and consumes no byte; `xfer_size` is unchanged.
- R5: A read with a nonzero `phase` while the FIFO holds bytes puts the oldest byte on `rd_data` in first-in-first-out order and decrements `xfer_size`.
- R6: A read with a nonzero `phase` while the FIFO is empty leaves `rd_data` and `xfer_size` unchanged.
- R7: When a read leaves the read index equal to the write index, both indices return to zero. A FIFO drained after holding DEPTH-1 bytes then accepts DEPTH-1 new bytes without overrun.
- R8: `status_load` discards the FIFO content and queues `status_byte` followed by 0x00. It sets `xfer_size` to 2 and `flags` to 2.
- R9: `flush` sets `intr_code` to 0x08 (function complete) and `flags` to 0. It leaves the FIFO content and `xfer_size` unchanged.
- R10: Strobes in one cycle are served in the priority `status_load`, `flush`, data write, read. Only the highest is acted on, so a read in the same cycle as a write is ignored.
- R11: After reset, `rd_data`, `xfer_size`, `flags`, `intr_code`, `overrun` and `cmd_len` are all zero.
- R12: `cmd_clear` sets `cmd_len` to 0 and takes priority over a command-mode write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Data-register write strobe |
| wr_data | input | 8 | Byte written to the data register |
| rd_en | input | 1 | Data-register read strobe |
| phase | input | 3 | Bus phase bits from the status register |
| cmd_mode | input | 1 | Command-collection mode: writes go to the command buffer |
| cmd_clear | input | 1 | Empties the command buffer |
| cmd_idx | input | $clog2(CMD_DEPTH) | Command buffer read index |
| status_load | input | 1 | Status-response command strobe |
| status_byte | input | 8 | Status byte queued by the status-response command |
| flush | input | 1 | Flush command strobe |
| rd_data | output | 8 | Data-register read value, updated by reads |
| xfer_size | output | SIZE_W | Signed transfer size |
| flags | output | $clog2(DEPTH)+1 | Flags register byte count |
| intr_code | output | 8 | Interrupt register code |
| overrun | output | 1 | One-cycle pulse after a dropped write |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Bytes held in the command buffer |
| cmd_byte | output | 8 | Command byte at `cmd_idx` |

## Verification
The checker examines every cycle for the following conditions:
- The read index never passes the write index, and the two indices are equal only when both are zero.
- A data-out read yields zero and leaves the size count unchanged.
- A pop lowers the size count by one.
- Writes at the refusal slot or into a full command buffer change no pointer and raise the overrun pulse.
- The status-response load and the flush leave the size, flags and interrupt values given above.

Some behaviour shows only in the bench's scenarios:
- FIFO ordering of the actual byte values.
- Reuse of the full capacity after index rewind.
- Retention of FIFO content across a flush.
- Readback of captured command bytes.
- Which strobe wins when several arrive together.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
   localparam logic [7:0] INTR_FUNC_DONE = 8'h08;
   localparam logic [2:0] PHASE_DATA_OUT = 3'b000;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_STATUS,
      OP_FLUSH,
      OP_WRITE,
      OP_READ
   } op_e;
endpackage

// File: rtl/pio_op_arbiter.sv
module pio_op_arbiter
   import pio_fifo_pkg::*;
(
   input  logic status_load,
   input  logic flush,
   input  logic wr_en,
   input  logic rd_en,
   output op_e  op
);
   always_comb begin
      if (status_load)  op = OP_STATUS;
      else if (flush)   op = OP_FLUSH;
      else if (wr_en)   op = OP_WRITE;
      else if (rd_en)   op = OP_READ;
      else              op = OP_NONE;
   end
endmodule

// File: rtl/pio_data_store.sv
module pio_data_store
   import pio_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op,
   input  logic             cmd_mode,
   input  logic [7:0]       wr_data,
   input  logic [2:0]       phase,
   input  logic [7:0]       status_byte,
   output logic [7:0]       rd_data,
   output logic             push,
   output logic             pop,
   output logic             drop,
   output logic [PTR_W-1:0] rptr,
   output logic [PTR_W-1:0] wptr
);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [PTR_W-1:0] IDX_ONE  = PTR_W'(1);
   localparam logic [PTR_W-1:0] IDX_TWO  = PTR_W'(2);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] rptr_next;
   logic             data_wr;
   logic             data_out_phase;

   assign data_wr        = (op == OP_WRITE) && !cmd_mode;
   assign push           = data_wr && (wptr != LAST_IDX);
   assign drop           = data_wr && (wptr == LAST_IDX);
   assign data_out_phase = (phase == PHASE_DATA_OUT);
   assign pop            = (op == OP_READ) && !data_out_phase && (rptr < wptr);
   assign rptr_next      = pop ? rptr + IDX_ONE : rptr;

   always_ff @(posedge clk) begin
      if (op == OP_STATUS) begin
         mem[0] <= status_byte;
         mem[1] <= 8'h00;
      end else if (push) begin
         mem[wptr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr    <= '0;
         wptr    <= '0;
         rd_data <= 8'h00;
      end else begin
         case (op)
            OP_STATUS: begin
               rptr <= '0;
               wptr <= IDX_TWO;
            end
            OP_WRITE: begin
               if (push) wptr <= wptr + IDX_ONE;
            end
            OP_READ: begin
               if (data_out_phase) rd_data <= 8'h00;
               else if (pop)       rd_data <= mem[rptr];
               if (rptr_next == wptr) begin
                  rptr <= '0;
                  wptr <= '0;
               end else begin
                  rptr <= rptr_next;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pio_cmd_buffer.sv
module pio_cmd_buffer
   import pio_fifo_pkg::*;
#(
   parameter int CMD_DEPTH    = 16,
   parameter bit REG_CMD_READ = 1'b0,
   localparam int CIDX_W = $clog2(CMD_DEPTH),
   localparam int CLEN_W = $clog2(CMD_DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op,
   input  logic              cmd_mode,
   input  logic              cmd_clear,
   input  logic [7:0]        wr_data,
   input  logic [CIDX_W-1:0] cmd_idx,
   output logic [CLEN_W-1:0] cmd_len,
   output logic [7:0]        cmd_byte,
   output logic              drop
);
   localparam logic [CLEN_W-1:0] FULL_LEN = CLEN_W'(CMD_DEPTH);

   logic [7:0] cbuf [CMD_DEPTH];
   logic       cmd_wr;
   logic       accept;

   assign cmd_wr = (op == OP_WRITE) && cmd_mode && !cmd_clear;
   assign accept = cmd_wr && (cmd_len != FULL_LEN);
   assign drop   = cmd_wr && (cmd_len == FULL_LEN);

   always_ff @(posedge clk) begin
      if (accept) cbuf[cmd_len[CIDX_W-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         cmd_len <= '0;
      else if (cmd_clear) cmd_len <= '0;
      else if (accept)    cmd_len <= cmd_len + CLEN_W'(1);
   end

   generate
      if (REG_CMD_READ) begin : g_reg_read
         always_ff @(posedge clk) begin
            if (!rst_n) cmd_byte <= 8'h00;
            else        cmd_byte <= cbuf[cmd_idx];
         end
      end else begin : g_comb_read
         assign cmd_byte = cbuf[cmd_idx];
      end
   endgenerate
endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo
   import pio_fifo_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int CMD_DEPTH    = 16,
   parameter int SIZE_W       = 16,
   parameter bit REG_CMD_READ = 1'b0,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CIDX_W = $clog2(CMD_DEPTH),
   localparam int CLEN_W = $clog2(CMD_DEPTH + 1)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [7:0]               wr_data,
   input  logic                     rd_en,
   input  logic [2:0]               phase,
   input  logic                     cmd_mode,
   input  logic                     cmd_clear,
   input  logic [CIDX_W-1:0]        cmd_idx,
   input  logic                     status_load,
   input  logic [7:0]               status_byte,
   input  logic                     flush,
   output logic [7:0]               rd_data,
   output logic signed [SIZE_W-1:0] xfer_size,
   output logic [PTR_W:0]           flags,
   output logic [7:0]               intr_code,
   output logic                     overrun,
   output logic [CLEN_W-1:0]        cmd_len,
   output logic [7:0]               cmd_byte
);
   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 4");
      assert (CMD_DEPTH >= 2 && (CMD_DEPTH & (CMD_DEPTH - 1)) == 0)
         else $error("CMD_DEPTH must be a power of two of at least 2");
      assert (SIZE_W > PTR_W + 1)
         else $error("SIZE_W too narrow for DEPTH");
   end

   op_e              op;
   logic             push, pop, data_drop, cmd_drop;
   logic [PTR_W-1:0] rptr, wptr;

   pio_op_arbiter u_arb (
      .status_load (status_load),
      .flush       (flush),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .op          (op)
   );

   pio_data_store #(.DEPTH(DEPTH)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .cmd_mode    (cmd_mode),
      .wr_data     (wr_data),
      .phase       (phase),
      .status_byte (status_byte),
      .rd_data     (rd_data),
      .push        (push),
      .pop         (pop),
      .drop        (data_drop),
      .rptr        (rptr),
      .wptr        (wptr)
   );

   pio_cmd_buffer #(.CMD_DEPTH(CMD_DEPTH), .REG_CMD_READ(REG_CMD_READ)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .cmd_mode  (cmd_mode),
      .cmd_clear (cmd_clear),
      .wr_data   (wr_data),
      .cmd_idx   (cmd_idx),
      .cmd_len   (cmd_len),
      .cmd_byte  (cmd_byte),
      .drop      (cmd_drop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_size <= '0;
         flags     <= '0;
         intr_code <= 8'h00;
         overrun   <= 1'b0;
      end else begin
         overrun <= data_drop | cmd_drop;
         case (op)
            OP_STATUS: begin
               xfer_size <= SIZE_W'(2);
               flags     <= (PTR_W + 1)'(2);
            end
            OP_FLUSH: begin
               flags     <= '0;
               intr_code <= INTR_FUNC_DONE;
            end
            default: begin
               if (push)     xfer_size <= xfer_size + SIZE_W'(1);
               else if (pop) xfer_size <= xfer_size - SIZE_W'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/pio_byte_fifo_checker.sv
module pio_byte_fifo_checker
   import pio_fifo_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int CMD_DEPTH = 16,
   parameter int SIZE_W    = 16,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CLEN_W = $clog2(CMD_DEPTH + 1)
)(
   input logic                     clk,
   input logic                     rst_n,
   input op_e                      op,
   input logic                     cmd_mode,
   input logic                     cmd_clear,
   input logic [2:0]               phase,
   input logic [PTR_W-1:0]         rptr,
   input logic [PTR_W-1:0]         wptr,
   input logic [7:0]               rd_data,
   input logic signed [SIZE_W-1:0] xfer_size,
   input logic [PTR_W:0]           flags,
   input logic [7:0]               intr_code,
   input logic                     overrun,
   input logic [CLEN_W-1:0]        cmd_len
);
   localparam logic [PTR_W-1:0]  LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CLEN_W-1:0] FULL_LEN = CLEN_W'(CMD_DEPTH);

   a_r1_cmd_append: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && cmd_mode && !cmd_clear && cmd_len != FULL_LEN)
      |=> cmd_len == $past(cmd_len) + CLEN_W'(1));

   a_r2_cmd_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && cmd_mode && !cmd_clear && cmd_len == FULL_LEN)
      |=> (overrun && $stable(cmd_len)));

   a_r3_fifo_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && !cmd_mode && wptr == LAST_IDX)
      |=> (overrun && $stable(wptr) && $stable(xfer_size)));

   a_r4_data_out_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ && phase == PHASE_DATA_OUT)
      |=> (rd_data == 8'h00 && $stable(xfer_size)));

   a_r5_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ && phase != PHASE_DATA_OUT && rptr < wptr)
      |=> xfer_size == $past(xfer_size) - SIZE_W'(1));

   a_r7_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      (rptr == wptr) |-> (wptr == '0));

   a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
      rptr <= wptr);

   a_r8_status_load: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_STATUS) |=> (xfer_size == SIZE_W'(2) && flags == (PTR_W + 1)'(2)));

   a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FLUSH)
      |=> (intr_code == INTR_FUNC_DONE && flags == '0 && $stable(xfer_size)));
endmodule

bind pio_byte_fifo pio_byte_fifo_checker #(
   .DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .SIZE_W(SIZE_W)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .op        (op),
   .cmd_mode  (cmd_mode),
   .cmd_clear (cmd_clear),
   .phase     (phase),
   .rptr      (rptr),
   .wptr      (wptr),
   .rd_data   (rd_data),
   .xfer_size (xfer_size),
   .flags     (flags),
   .intr_code (intr_code),
   .overrun   (overrun),
   .cmd_len   (cmd_len)
);

// File: tb/pio_byte_fifo_bench.sv
`timescale 1ns/1ps
module pio_byte_fifo_bench;
   localparam int DEPTH = 16;
   localparam int CMD_DEPTH = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0, rd_en = 1'b0, cmd_mode = 1'b0, cmd_clear = 1'b0;
   logic               status_load = 1'b0, flush = 1'b0;
   logic [7:0]         wr_data = 8'h00, status_byte = 8'h00;
   logic [2:0]         phase = 3'b001;
   logic [3:0]         cmd_idx = 4'd0;
   logic [7:0]         rd_data, intr_code, cmd_byte;
   logic signed [15:0] xfer_size;
   logic [4:0]         flags, cmd_len;
   logic               overrun;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   pio_byte_fifo u_pio_byte_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .phase(phase), .cmd_mode(cmd_mode), .cmd_clear(cmd_clear), .cmd_idx(cmd_idx),
      .status_load(status_load), .status_byte(status_byte), .flush(flush),
      .rd_data(rd_data), .xfer_size(xfer_size), .flags(flags), .intr_code(intr_code),
      .overrun(overrun), .cmd_len(cmd_len), .cmd_byte(cmd_byte)
   );

   typedef struct packed {
      logic [1:0]  op;      // 0 write, 1 read, 2 status load, 3 flush
      logic [7:0]  d;
      logic [2:0]  ph;
      logic [7:0]  exp_rd;
      logic [15:0] exp_size;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'h11, 3'd1, 8'h00, 16'd1},   // R3 store
      '{2'd0, 8'h22, 3'd1, 8'h00, 16'd2},   // R3 store
      '{2'd1, 8'h00, 3'd1, 8'h11, 16'd1},   // R5 oldest first
      '{2'd1, 8'h00, 3'd0, 8'h00, 16'd1},   // R4 data-out read
      '{2'd1, 8'h00, 3'd1, 8'h22, 16'd0},   // R5 / R7 empties
      '{2'd1, 8'h00, 3'd1, 8'h22, 16'd0},   // R6 empty read holds
      '{2'd2, 8'h5A, 3'd1, 8'h22, 16'd2},   // R8 status load
      '{2'd1, 8'h00, 3'd3, 8'h5A, 16'd1},   // R8 status byte first
      '{2'd1, 8'h00, 3'd3, 8'h00, 16'd0},   // R8 zero byte second
      '{2'd3, 8'h00, 3'd1, 8'h00, 16'd0}    // R9 flush
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clr();
      wr_en = 0; rd_en = 0; status_load = 0; flush = 0; cmd_clear = 0;
   endtask

   task automatic cyc();
      @(negedge clk);
      clr();
   endtask

   task automatic wr(input logic [7:0] d);
      wr_data = d; wr_en = 1; cyc();
   endtask

   task automatic rd(input logic [2:0] ph);
      phase = ph; rd_en = 1; cyc();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state
      chk("R11 rd_data", rd_data, 0);
      chk("R11 xfer_size", xfer_size, 0);
      chk("R11 flags", flags, 0);
      chk("R11 intr_code", intr_code, 0);
      chk("R11 overrun", overrun, 0);
      chk("R11 cmd_len", cmd_len, 0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            2'd0: begin wr_data = VECS[i].d; wr_en = 1; end
            2'd1: rd_en = 1;
            2'd2: begin status_byte = VECS[i].d; status_load = 1; end
            default: flush = 1;
         endcase
         phase = VECS[i].ph;
         cyc();
         chk($sformatf("vec%0d rd_data", i), rd_data, VECS[i].exp_rd);
         chk($sformatf("vec%0d xfer_size", i), xfer_size, int'(signed'(VECS[i].exp_size)));
      end
      chk("R9 intr_code after flush", intr_code, 8'h08);
      chk("R9 flags after flush", flags, 0);

      // R3 fill to DEPTH-1, then refused write
      for (int i = 0; i < DEPTH - 1; i++) wr(8'h40 + 8'(i));
      chk("R3 size at capacity", xfer_size, DEPTH - 1);
      chk("R3 no overrun at last good write", overrun, 0);
      wr(8'hEE);
      chk("R3 refused write overrun", overrun, 1);
      chk("R3 refused write size", xfer_size, DEPTH - 1);
      // R5 drain in order
      for (int i = 0; i < DEPTH - 1; i++) begin
         rd(3'b001);
         chk($sformatf("R5 drain %0d", i), rd_data, 8'h40 + i);
      end
      chk("R5 size drained", xfer_size, 0);
      // R7 rewind gives full capacity again
      for (int i = 0; i < DEPTH - 1; i++) wr(8'h80 + 8'(i));
      chk("R7 refill no overrun", overrun, 0);
      chk("R7 refill size", xfer_size, DEPTH - 1);
      rd(3'b001);
      chk("R7 refill first byte", rd_data, 8'h80);

      // R8 / R10 status load wins over write, discards content
      status_byte = 8'hC3; status_load = 1; wr_data = 8'h99; wr_en = 1; cyc();
      chk("R10 status over write size", xfer_size, 2);
      chk("R8 flags", flags, 2);
      rd(3'b010);
      chk("R8 status byte", rd_data, 8'hC3);
      rd(3'b010);
      chk("R8 trailing zero", rd_data, 8'h00);
      wr(8'h5C);
      rd(3'b010);
      chk("R8 old content gone", rd_data, 8'h5C);

      // R9 flush keeps FIFO content
      wr(8'hA1); wr(8'hA2);
      flush = 1; cyc();
      chk("R9 flush keeps size", xfer_size, 2);
      chk("R9 flush flags", flags, 0);
      rd(3'b001);
      chk("R9 content after flush", rd_data, 8'hA1);

      // R10 read ignored when write in same cycle
      wr_data = 8'h77; wr_en = 1; rd_en = 1; phase = 3'b001; cyc();
      chk("R10 read ignored rd_data", rd_data, 8'hA1);
      chk("R10 write taken size", xfer_size, 2);
      rd(3'b001);
      chk("R10 next byte", rd_data, 8'hA2);
      rd(3'b001);
      chk("R10 written byte", rd_data, 8'h77);

      // R1 / R2 / R12 command buffer
      cmd_mode = 1;
      for (int i = 0; i < CMD_DEPTH; i++) wr(8'hD0 + 8'(i));
      chk("R1 cmd_len full", cmd_len, CMD_DEPTH);
      chk("R1 xfer_size untouched", xfer_size, 0);
      wr(8'hFF);
      chk("R2 cmd overrun", overrun, 1);
      chk("R2 cmd_len held", cmd_len, CMD_DEPTH);
      cmd_idx = 4'd0; #1;
      chk("R1 cmd byte 0", cmd_byte, 8'hD0);
      cmd_idx = 4'd15; #1;
      chk("R2 last cmd byte kept", cmd_byte, 8'hDF);
      @(negedge clk);
      cmd_clear = 1; wr_data = 8'h33; wr_en = 1; cyc();
      chk("R12 clear wins", cmd_len, 0);
      wr(8'h44);
      chk("R1 append after clear", cmd_len, 1);
      cmd_idx = 4'd0; #1;
      chk("R1 appended byte", cmd_byte, 8'h44);
      cmd_mode = 0;
      rd(3'b001);
      chk("R1 FIFO untouched by cmd writes", rd_data, 8'h77);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule